// File: doc/BRIEF.md
# H-Bridge Gate Sequencer

This block drives the four switches of one full bridge: a high-side and a low-side switch on each of two output legs, called A and B. It takes three plain command inputs and a fault input and turns them into four switch enables. The commands select forward drive, reverse drive, a brake with both low sides on, or disable with all switches off. Every input first passes through a two-stage synchronizer, so the commands may come from another clock domain or from a PWM source with no timing relation to the clock.

Stopping a forward or reverse drive in favour of the brake would briefly turn on the low side of the leg whose high side is still on. To avoid this, the sequencer holds all four switches off for a dead-time window before it applies the brake. The window is a cycle count computed from the clock period and the wanted dead time. Other transitions do not get this window, and neither does leaving disable. While the fault input is high, all switches are forced off. When the fault clears, the commanded state returns without needing a reset.

Top module: `hbridge_gate_seq`

## Requirements
- R1: Command decoding, with gate vector {hi_a, lo_a, hi_b, lo_b}:
  - cmd_en=0 gives disable (0000), whatever the other two inputs are.
  - cmd_en=1, cmd_mode=1, cmd_dir=0 gives forward (1001).
  - cmd_en=1, cmd_mode=1, cmd_dir=1 gives reverse (0110).
  - cmd_en=1, cmd_mode=0 gives brake (0101).
  - All inputs held low read as disable.
- R2: A command change reaches the gate outputs on the third rising clock edge after it is applied: two synchronizer stages, then the state register. It does not appear earlier.
- R3: A change from forward or reverse to brake holds all four gates off for exactly DEAD_CYCLES cycles, then applies brake. DEAD_CYCLES is ceil(DEAD_TIME_PS / CLK_PERIOD_PS), with a minimum of 1. Brake never directly follows a drive state.
- R4: All other transitions take effect with no dead time. This covers disable to any on state, brake to forward or reverse, and forward to reverse.
- R5: A command other than brake that arrives during a dead-time window ends the window and is applied at once. A later return to brake from drive starts a full new window.
- R6: All gates are off from the second rising edge after fault rises, and they stay off for as long as fault is high.
- R7: Once fault falls, the commanded state is applied on the third rising edge, with no dead time and no reset needed.
- R8: The high-side and low-side gates of the same leg are never on in the same cycle.
- R9: A synchronous active-low reset turns all gates off and puts the state in disable.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_en | input | 1 | Enable command (0 = disable) |
| cmd_dir | input | 1 | Direction command (0 = forward, 1 = reverse) |
| cmd_mode | input | 1 | Mode command (1 = drive, 0 = brake) |
| fault | input | 1 | Fault input: any fault condition, active high |
| hi_a | output | 1 | High-side gate enable, leg A |
| lo_a | output | 1 | Low-side gate enable, leg A |
| hi_b | output | 1 | High-side gate enable, leg B |
| lo_b | output | 1 | Low-side gate enable, leg B |

## Verification
The bench keeps CLK_PERIOD_PS at 8000 and overrides DEAD_TIME_PS to 40000, so the dead-time window is five cycles. This keeps every cycle of the window observable. A change of command in the middle of the window can then land at a known count, and its early exit and the fresh window that follows can be told apart from a completed window. The default dead time gives 52 cycles. That uses the same counter logic, only with a wider compare.

// File: rtl/hbg_pkg.sv
package hbg_pkg;

  typedef enum logic [1:0] {
    DRV_OFF   = 2'd0,
    DRV_FWD   = 2'd1,
    DRV_REV   = 2'd2,
    DRV_BRAKE = 2'd3
  } drive_e;

  typedef struct packed {
    logic hi_a;
    logic lo_a;
    logic hi_b;
    logic lo_b;
  } gates_t;

  function automatic gates_t gates_of(drive_e d);
    gates_t g;
    g = '0;
    case (d)
      DRV_FWD:   begin g.hi_a = 1'b1; g.lo_b = 1'b1; end
      DRV_REV:   begin g.hi_b = 1'b1; g.lo_a = 1'b1; end
      DRV_BRAKE: begin g.lo_a = 1'b1; g.lo_b = 1'b1; end
      default:   g = '0;
    endcase
    return g;
  endfunction

endpackage

// File: rtl/hbg_sync.sv
module hbg_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [STAGES-1:0][WIDTH-1:0] pipe;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rst_n) pipe[s] <= '0;
          else        pipe[s] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rst_n) pipe[s] <= '0;
          else        pipe[s] <= pipe[s-1];
        end
      end
    end
  endgenerate

  assign q = pipe[STAGES-1];

endmodule

// File: rtl/hbg_decode.sv
module hbg_decode
  import hbg_pkg::*;
(
  input  logic   en,
  input  logic   dir,
  input  logic   mode,
  output drive_e target
);

  always_comb begin
    if (!en)       target = DRV_OFF;
    else if (!mode) target = DRV_BRAKE;
    else if (dir)  target = DRV_REV;
    else           target = DRV_FWD;
  end

endmodule

// File: rtl/hbg_seq.sv
module hbg_seq
  import hbg_pkg::*;
#(
  parameter int DEAD_CYCLES = 52,
  localparam int CNT_W = (DEAD_CYCLES < 2) ? 1 : $clog2(DEAD_CYCLES)
) (
  input  logic   clk,
  input  logic   rst_n,
  input  drive_e target,
  input  logic   fault_s,
  output gates_t gates
);

  localparam logic [CNT_W-1:0] LAST = CNT_W'(DEAD_CYCLES - 1);

  drive_e          cur;
  logic            blanking;
  logic [CNT_W-1:0] cnt;
  logic            leaving_drive;

  assign leaving_drive = (cur == DRV_FWD) || (cur == DRV_REV);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur      <= DRV_OFF;
      blanking <= 1'b0;
      cnt      <= '0;
    end else if (fault_s) begin
      cur      <= DRV_OFF;
      blanking <= 1'b0;
      cnt      <= '0;
    end else if (blanking) begin
      if (target != DRV_BRAKE) begin
        cur      <= target;
        blanking <= 1'b0;
        cnt      <= '0;
      end else if (cnt == LAST) begin
        cur      <= DRV_BRAKE;
        blanking <= 1'b0;
        cnt      <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end else if (target != cur) begin
      if (leaving_drive && target == DRV_BRAKE) begin
        cur      <= DRV_OFF;
        blanking <= 1'b1;
        cnt      <= '0;
      end else begin
        cur <= target;
      end
    end
  end

  assign gates = fault_s ? '0 : gates_of(cur);

endmodule

// File: rtl/hbridge_gate_seq.sv
module hbridge_gate_seq
  import hbg_pkg::*;
#(
  parameter int CLK_PERIOD_PS = 8000,
  parameter int DEAD_TIME_PS  = 415000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cmd_en,
  input  logic cmd_dir,
  input  logic cmd_mode,
  input  logic fault,
  output logic hi_a,
  output logic lo_a,
  output logic hi_b,
  output logic lo_b
);

  localparam int DEAD_RAW    = (DEAD_TIME_PS + CLK_PERIOD_PS - 1) / CLK_PERIOD_PS;
  localparam int DEAD_CYCLES = (DEAD_RAW < 1) ? 1 : DEAD_RAW;

  logic [3:0] raw_in;
  logic [3:0] sync_in;
  drive_e     target;
  gates_t     gates;

  assign raw_in = {fault, cmd_en, cmd_dir, cmd_mode};

  hbg_sync #(.WIDTH(4), .STAGES(2)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (raw_in),
    .q    (sync_in)
  );

  hbg_decode u_decode (
    .en    (sync_in[2]),
    .dir   (sync_in[1]),
    .mode  (sync_in[0]),
    .target(target)
  );

  hbg_seq #(.DEAD_CYCLES(DEAD_CYCLES)) u_seq (
    .clk    (clk),
    .rst_n  (rst_n),
    .target (target),
    .fault_s(sync_in[3]),
    .gates  (gates)
  );

  assign hi_a = gates.hi_a;
  assign lo_a = gates.lo_a;
  assign hi_b = gates.hi_b;
  assign lo_b = gates.lo_b;

endmodule

// File: rtl/hbg_checker.sv
module hbg_checker (
  input logic clk,
  input logic rst_n,
  input logic fault,
  input logic hi_a,
  input logic lo_a,
  input logic hi_b,
  input logic lo_b
);

  logic drive_now, brake_now, all_off;
  assign drive_now = (hi_a && lo_b) || (hi_b && lo_a);
  assign brake_now = lo_a && lo_b && !hi_a && !hi_b;
  assign all_off   = !(hi_a || lo_a || hi_b || lo_b);

  assert_leg_a_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(hi_a && lo_a));

  assert_leg_b_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(hi_b && lo_b));

  assert_one_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({hi_a, hi_b}));

  assert_no_direct_brake_R3: assert property (@(posedge clk) disable iff (!rst_n)
    drive_now |=> !brake_now);

  assert_fault_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(fault, 2) && $past(rst_n, 2) && $past(rst_n)) |-> all_off);

  assert_reset_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> all_off);

endmodule

bind hbridge_gate_seq hbg_checker u_chk (.*);

// File: tb/hbridge_gate_seq_bench.sv
module hbridge_gate_seq_bench;

  localparam logic [3:0] G_OFF = 4'b0000;
  localparam logic [3:0] G_FWD = 4'b1001;
  localparam logic [3:0] G_REV = 4'b0110;
  localparam logic [3:0] G_BRK = 4'b0101;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_en = 1'b0, cmd_dir = 1'b0, cmd_mode = 1'b0, fault = 1'b0;
  logic hi_a, lo_a, hi_b, lo_b;
  int   checks = 0, errors = 0, overlaps = 0;
  bit   done = 1'b0;

  always #4 clk = ~clk;

  hbridge_gate_seq #(.CLK_PERIOD_PS(8000), .DEAD_TIME_PS(40000)) u_hbridge_gate_seq (
    .clk(clk), .rst_n(rst_n), .cmd_en(cmd_en), .cmd_dir(cmd_dir),
    .cmd_mode(cmd_mode), .fault(fault),
    .hi_a(hi_a), .lo_a(lo_a), .hi_b(hi_b), .lo_b(lo_b)
  );

  always @(negedge clk)
    if (rst_n && ((hi_a && lo_a) || (hi_b && lo_b))) overlaps++;

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_cmd(input logic en, input logic dir, input logic mode);
    cmd_en = en; cmd_dir = dir; cmd_mode = mode;
  endtask

  task automatic check(input string tag, input logic [3:0] exp);
    logic [3:0] act;
    act = {hi_a, lo_a, hi_b, lo_b};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: gates=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic go(input logic en, input logic dir, input logic mode);
    set_cmd(en, dir, mode);
    tick(8);
  endtask

  task automatic t_reset;
    rst_n = 1'b0; set_cmd(0, 0, 0); fault = 1'b0;
    tick(3);
    check("R9 reset gates off", G_OFF);
    rst_n = 1'b1;
    tick(3);
    check("R1 all inputs low read as disable", G_OFF);
  endtask

  task automatic t_encode;
    set_cmd(1, 0, 1);
    tick(2);
    check("R2 no change before third edge", G_OFF);
    tick(1);
    check("R2 R4 disable to forward on third edge", G_FWD);
    set_cmd(1, 1, 1); tick(3);
    check("R1 R4 forward to reverse direct", G_REV);
    set_cmd(0, 1, 1); tick(3);
    check("R1 en low disables regardless of dir and mode", G_OFF);
    set_cmd(1, 1, 0); tick(3);
    check("R4 disable to brake without dead time", G_BRK);
    set_cmd(1, 0, 1); tick(3);
    check("R4 brake to forward direct", G_FWD);
  endtask

  task automatic t_blank;
    go(1, 0, 1);
    set_cmd(1, 0, 0);
    tick(3); check("R3 forward to brake starts all off", G_OFF);
    tick(4); check("R3 still off at last dead cycle", G_OFF);
    tick(1); check("R3 brake after five dead cycles", G_BRK);
    go(1, 1, 1);
    check("R4 brake to reverse direct", G_REV);
    set_cmd(1, 1, 0);
    tick(7); check("R3 reverse to brake off through window", G_OFF);
    tick(1); check("R3 reverse to brake applied", G_BRK);
  endtask

  task automatic t_midchange;
    go(1, 0, 1);
    set_cmd(1, 0, 0);
    tick(4); check("R5 inside dead window", G_OFF);
    set_cmd(1, 1, 1);
    tick(2); check("R5 still off before new command lands", G_OFF);
    tick(1); check("R5 window abandoned for reverse", G_REV);
    set_cmd(1, 0, 0);
    tick(7); check("R5 fresh window full length", G_OFF);
    tick(1); check("R5 brake after fresh window", G_BRK);
  endtask

  task automatic t_fault;
    go(1, 0, 1);
    fault = 1'b1;
    tick(1); check("R6 one edge after fault still driving", G_FWD);
    tick(1); check("R6 gates off on second edge", G_OFF);
    tick(10); check("R6 held off while fault high", G_OFF);
    fault = 1'b0;
    tick(2); check("R7 off until third edge after release", G_OFF);
    tick(1); check("R7 forward resumes", G_FWD);
    go(1, 1, 1);
    fault = 1'b1; set_cmd(1, 1, 0);
    tick(5); check("R6 off under fault with brake commanded", G_OFF);
    fault = 1'b0;
    tick(3); check("R7 brake resumes without dead time", G_BRK);
  endtask

  task automatic t_midreset;
    go(1, 0, 1);
    rst_n = 1'b0;
    tick(1); check("R9 synchronous reset clears drive", G_OFF);
    rst_n = 1'b1; set_cmd(0, 0, 0);
    tick(1); check("R9 stays off after reset release", G_OFF);
  endtask

  initial begin
    t_reset();
    t_encode();
    t_blank();
    t_midchange();
    t_fault();
    t_midreset();
    checks++;
    if (overlaps != 0) begin
      errors++;
      $display("FAIL R8 leg overlap cycles=%0d expected=0", overlaps);
    end
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog: run incomplete expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule